// File: doc/BRIEF.md
# Zero-Voltage-Switching Gate Sequencer

This block drives the two gate enables of one resonant bridge leg from a single switch-request bit. A request of one selects the high-side device, and a request of zero selects the low-side device. The sequencer turns the outgoing device off on the first clock edge that sees the new request. It then holds both gates off until the incoming device reports zero voltage across it. No fixed dead time is used: the turn-on is gated only by the zero-voltage report.

Each device has an active-low zero-voltage indicator. The indicator is low while that device's antiparallel diode conducts and high otherwise. Both indicators arrive asynchronously, so they are synchronized before use. They are also qualified over two consecutive synchronized samples, so that a single-cycle glitch cannot close a switch. A wait that runs too long ends in a latched fault with both gates off. A start-up inhibit holds the leg off and clears that fault. When the inhibit is released, the sequencer begins waiting on the side that the request names.

Top module: `zvs_gate_seq`

## Requirements
- R1: While `inhibit` is high, both `gate_hi` and `gate_lo` are low from the edge after `inhibit` is sampled, whatever `req` and the indicators do. On the first edge with `inhibit` low, the sequencer starts a wait on the side that `req` selects.
- R2: The low-side command is the inverse of the request. `req`=1 selects the high-side device and `req`=0 selects the low-side device. Only the selected device can be switched on.
- R3: When `req` is 1 and the low side is on, `gate_lo` drops at the next edge. `gate_hi` stays low until the high-side indicator has been qualified.
- R4: When `req` is 0 and the high side is on, `gate_hi` drops at the next edge. `gate_lo` stays low until the low-side indicator has been qualified.
- R5: The indicators are active low: 0 means zero voltage. Each one passes through a two-flop synchronizer that resets to 1, so a level driven before edge k is first seen by the sequencing decision at edge k+2.
- R6: A turn-on needs two consecutive synchronized low samples of the awaited indicator, both taken inside the current wait. This holds even when the indicator is already low as the wait begins, so a single low sample never switches a device on.
- R7: `gate_hi` and `gate_lo` are never high in the same cycle, and every rising gate enable follows a cycle in which both enables were low.
- R8: If a wait lasts `TIMEOUT_CYCLES` cycles without qualification, both gates stay low and `fault` goes high. `fault` stays high until `rst` or `inhibit`, and no request or indicator activity clears it.
- R9: If `req` reverses during a wait, the pending turn-on is dropped at the next edge. A new wait then starts on the other device with a fresh qualification and a fresh timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inhibit | input | 1 | Start-up inhibit: holds both gates off and clears the fault |
| req | input | 1 | Switch request: 1 selects the high side, 0 selects the low side |
| zv_hi_n | input | 1 | High-side zero-voltage indicator, active low, asynchronous |
| zv_lo_n | input | 1 | Low-side zero-voltage indicator, active low, asynchronous |
| gate_hi | output | 1 | High-side gate enable (registered) |
| gate_lo | output | 1 | Low-side gate enable (registered) |
| fault | output | 1 | Sticky flag for a zero-voltage wait that timed out |

## Verification
The bench builds the block with `TIMEOUT_CYCLES`=8 and the synchronizer depth at 2. With this short window, a missing indicator reaches the fault within a few cycles, and a one-cycle glitch is followed by a complete timeout. The same short window lets a request reversal in the middle of a wait be timed against a timer that is almost expired. A random phase with fast toggling of the request and both indicators then drives many overlapping waits, reversals and faults against the cycle-level model.

// File: rtl/zvs_seq_pkg.sv
package zvs_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HI_ON   = 3'd1,
    ST_LO_ON   = 3'd2,
    ST_WAIT_HI = 3'd3,
    ST_WAIT_LO = 3'd4,
    ST_FAULT   = 3'd5
  } seq_state_t;
endpackage

// File: rtl/zvs_sync.sv
module zvs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/zvs_zv_qual.sv
module zvs_zv_qual (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic zv_n_s,
  output logic ok
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst || clr) seen_q <= 1'b0;
    else if (en)    seen_q <= ~zv_n_s;
  end
  assign ok = ~zv_n_s & seen_q;
endmodule

// File: rtl/zvs_wait_timer.sv
module zvs_wait_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en)    cnt_q <= cnt_q + 1'b1;
  end
  assign expired = (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/zvs_gate_seq.sv
module zvs_gate_seq
  import zvs_seq_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic inhibit,
  input  logic req,
  input  logic zv_hi_n,
  input  logic zv_lo_n,
  output logic gate_hi,
  output logic gate_lo,
  output logic fault
);
  localparam int N_IND = 2;

  seq_state_t state, state_n;
  logic [N_IND-1:0] zv_s;
  logic zh_s, zl_s, wait_zv_s, in_wait, clr, qual_ok, tmo;

  zvs_sync #(.WIDTH(N_IND), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i({zv_lo_n, zv_hi_n}), .sync_o(zv_s)
  );
  assign zh_s = zv_s[0];
  assign zl_s = zv_s[1];

  assign in_wait   = (state == ST_WAIT_HI) || (state == ST_WAIT_LO);
  assign wait_zv_s = (state == ST_WAIT_HI) ? zh_s : zl_s;

  always_comb begin
    state_n = state;
    if (inhibit) state_n = ST_IDLE;
    else begin
      case (state)
        ST_IDLE:    state_n = req ? ST_WAIT_HI : ST_WAIT_LO;
        ST_HI_ON:   if (!req) state_n = ST_WAIT_LO;
        ST_LO_ON:   if (req)  state_n = ST_WAIT_HI;
        ST_WAIT_HI: begin
          if (!req)         state_n = ST_WAIT_LO;
          else if (qual_ok) state_n = ST_HI_ON;
          else if (tmo)     state_n = ST_FAULT;
        end
        ST_WAIT_LO: begin
          if (req)          state_n = ST_WAIT_HI;
          else if (qual_ok) state_n = ST_LO_ON;
          else if (tmo)     state_n = ST_FAULT;
        end
        ST_FAULT:   state_n = ST_FAULT;
        default:    state_n = ST_IDLE;
      endcase
    end
  end

  assign clr = ((state_n == ST_WAIT_HI) || (state_n == ST_WAIT_LO)) && (state_n != state);

  zvs_zv_qual u_qual (
    .clk(clk), .rst(rst), .clr(clr), .en(in_wait), .zv_n_s(wait_zv_s), .ok(qual_ok)
  );

  zvs_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .clr(clr), .en(in_wait), .expired(tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
      fault   <= 1'b0;
    end else begin
      state   <= state_n;
      gate_hi <= (state_n == ST_HI_ON);
      gate_lo <= (state_n == ST_LO_ON);
      fault   <= (state_n == ST_FAULT);
    end
  end

  AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> (!gate_hi && !gate_lo)); // R1
  AST_LO_DROP: assert property (@(posedge clk) disable iff (rst)
    (gate_lo && req && !inhibit) |=> !gate_lo); // R3
  AST_HI_DROP: assert property (@(posedge clk) disable iff (rst)
    (gate_hi && !req && !inhibit) |=> !gate_hi); // R4
  AST_HI_QUAL: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi) |-> (!$past(zh_s) && !$past(zh_s, 2))); // R6
  AST_LO_QUAL: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_lo) |-> (!$past(zl_s) && !$past(zl_s, 2))); // R6
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi && gate_lo)); // R7
  AST_BREAK_HI: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi) |-> !$past(gate_lo)); // R7
  AST_BREAK_LO: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_lo) |-> !$past(gate_hi)); // R7
  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!gate_hi && !gate_lo)); // R8
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fault && !inhibit) |=> fault); // R8
endmodule

// File: tb/zvs_gate_seq_tb_top.sv
module zvs_gate_seq_tb_top;
  localparam int TMO = 8;

  logic clk = 1'b0;
  logic rst = 1'b1, inhibit = 1'b0, req = 1'b0, zv_hi_n = 1'b1, zv_lo_n = 1'b1;
  logic gate_hi, gate_lo, fault;

  int n_checks = 0, n_errors = 0;
  bit done = 1'b0;

  // reference model state: 0 idle, 1 high on, 2 low on, 3 wait high, 4 wait low, 5 fault
  int mode = 0, run = 0, tmr = 0;
  int h1 = 1, h2 = 1, l1 = 1, l2 = 1;

  always #2 clk = ~clk;

  zvs_gate_seq #(.TIMEOUT_CYCLES(TMO), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .inhibit(inhibit), .req(req),
    .zv_hi_n(zv_hi_n), .zv_lo_n(zv_lo_n),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault(fault)
  );

  task automatic enter_wait(input int m);
    mode = m; run = 0; tmr = 0;
  endtask

  always @(posedge clk) begin
    int sh, sl;
    if (rst) begin
      mode = 0; run = 0; tmr = 0; h1 = 1; h2 = 1; l1 = 1; l2 = 1;
    end else begin
      sh = h2; sl = l2;
      h2 = h1; h1 = int'(zv_hi_n);
      l2 = l1; l1 = int'(zv_lo_n);
      if (inhibit) mode = 0;
      else begin
        case (mode)
          0: enter_wait(req ? 3 : 4);
          1: if (!req) enter_wait(4);
          2: if (req) enter_wait(3);
          3: if (!req) enter_wait(4);
             else if (sh == 0 && run == 1) mode = 1;
             else if (tmr == TMO - 1) mode = 5;
             else begin run = (sh == 0) ? 1 : 0; tmr++; end
          4: if (req) enter_wait(3);
             else if (sl == 0 && run == 1) mode = 2;
             else if (tmr == TMO - 1) mode = 5;
             else begin run = (sl == 0) ? 1 : 0; tmr++; end
          default: mode = 5;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s hi/lo/fault got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick(input string tag, input logic r, input logic inh,
                      input logic zh, input logic zl);
    @(negedge clk);
    check(tag, {gate_hi, gate_lo, fault},
          {mode == 1 ? 1'b1 : 1'b0, mode == 2 ? 1'b1 : 1'b0, mode == 5 ? 1'b1 : 1'b0});
    req = r; inhibit = inh; zv_hi_n = zh; zv_lo_n = zl;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset", {gate_hi, gate_lo, fault}, 3'b000);
    // R1: inhibit with the request and indicators moving
    for (int i = 0; i < 6; i++) tick("R1", i[0], 1'b1, 1'b0, 1'b0);
    check("R1 inhibit hold", {gate_hi, gate_lo, fault}, 3'b000);
    // R2: request low selects the low device
    for (int i = 0; i < 6; i++) tick("R2", 1'b0, 1'b0, 1'b1, 1'b0);
    check("R2 low side on", {gate_hi, gate_lo, fault}, 3'b010);
    // R3: rising request, high indicator already low
    tick("R3", 1'b0, 1'b0, 1'b0, 1'b0);
    tick("R3", 1'b1, 1'b0, 1'b0, 1'b1);
    tick("R3", 1'b1, 1'b0, 1'b0, 1'b1);
    check("R3 low dropped", {gate_hi, gate_lo, fault}, 3'b000);
    tick("R3", 1'b1, 1'b0, 1'b0, 1'b1);
    check("R3 wait qualifying", {gate_hi, gate_lo, fault}, 3'b000);
    tick("R3", 1'b1, 1'b0, 1'b0, 1'b1);
    check("R3 high on", {gate_hi, gate_lo, fault}, 3'b100);
    // R4: falling request, low indicator already low
    tick("R4", 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) tick("R4", 1'b0, 1'b0, 1'b1, 1'b0);
    check("R4 low on", {gate_hi, gate_lo, fault}, 3'b010);
    // R5: indicator latency through the synchronizer
    for (int i = 0; i < 4; i++) tick("R5", 1'b1, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) tick("R5", 1'b1, 1'b0, 1'b0, 1'b1);
    // R9: reversal mid-wait
    for (int i = 0; i < 4; i++) tick("R9", 1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) tick("R9", 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) tick("R9", 1'b0, 1'b0, 1'b1, 1'b0);
    check("R9 low on after reversal", {gate_hi, gate_lo, fault}, 3'b010);
    // R6: one-cycle glitch must not qualify, then R8 timeout
    tick("R6", 1'b1, 1'b0, 1'b1, 1'b1);
    tick("R6", 1'b1, 1'b0, 1'b1, 1'b1);
    tick("R6", 1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) tick("R6", 1'b1, 1'b0, 1'b1, 1'b1);
    check("R6 glitch ignored", {gate_hi, gate_lo}, 2'b00);
    for (int i = 0; i < 8; i++) tick("R8", 1'b1, 1'b0, 1'b1, 1'b1);
    check("R8 fault set", {gate_hi, gate_lo, fault}, 3'b001);
    for (int i = 0; i < 8; i++) tick("R8", i[1], 1'b0, 1'b0, 1'b0);
    check("R8 fault sticky", {gate_hi, gate_lo, fault}, 3'b001);
    tick("R8", 1'b1, 1'b1, 1'b0, 1'b0);
    tick("R8", 1'b1, 1'b1, 1'b0, 1'b0);
    check("R8 inhibit clears", {gate_hi, gate_lo, fault}, 3'b000);
    for (int i = 0; i < 6; i++) tick("R8", 1'b1, 1'b0, 1'b0, 1'b0);
    check("R8 recovered high on", {gate_hi, gate_lo, fault}, 3'b100);
    // R7: random traffic, all outputs compared to the model
    for (int i = 0; i < 2000; i++)
      tick("R7", ($urandom % 8) == 0 ? ~req : req, ($urandom % 97) == 0,
           ($urandom % 3) != 0, ($urandom % 3) != 0);
    tick("R7", 1'b0, 1'b0, 1'b1, 1'b1);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule